// File: doc/BRIEF.md
# CPU Extraction Word Stream Framer

This block sits between a switch queue and a processor. Frames leave the queue as a stream of 32-bit words with a last flag, a byte count for the final word, and flags that mark the frame as aborted or truncated. The processor pulls the frame one word per read strobe from a single data port. Every frame opens with a fixed number of internal header words. The payload words follow. Framing is carried in-band: a reserved band of eight word values, 0x80000000 through 0x80000007, acts as markers. Any payload word that falls inside that band is preceded by an escape marker, so the reader can always tell data from control.

A frame is closed by a marker that carries its outcome. That marker is a normal end with a valid-byte count, a truncation (pruned) or an abort. After it comes one final raw data word. A read that finds nothing to deliver returns the not-ready marker and changes nothing. A separate flag tells the processor that a frame is waiting. A two-bit flush control drains the queue side and returns the framer to the start of a frame.

Top module: `xfr_framer`

## Requirements
- R1: After a synchronous reset, the read word is 0x80000007 (not-ready), frame_waiting is 0 and src_ready is 0.
- R2: The first HDR_WORDS (default 4) words of each frame are returned raw, one per read, even when they equal a marker value.
- R3: A payload word that is not the last word and lies outside 0x80000000..0x80000007 is returned raw in a single read.
- R4: A non-last payload word inside 0x80000000..0x80000007 is delivered over two reads: first 0x80000006 (escape), then the raw word. The second read does not consume a queue word.
- R5: The last word of a frame with neither flag set is delivered as an end marker 0x80000000 | ((4 - n) mod 4), then the raw word. Here n is the valid-byte count coded on src_nbytes: code 0 means 4 bytes, and codes 1 to 3 mean that many bytes. The next frame starts again with its header.
- R6: A last word with src_prune set (and src_abort clear) is delivered as 0x80000004, then the raw word.
- R7: A last word with src_abort set is delivered as 0x80000005, then the raw word. Abort takes priority over prune.
- R8: A read when no queue word is offered and no word is held returns 0x80000007 and consumes nothing. This applies both between frames and in the middle of a frame, and the framer's position in the frame is unchanged.
- R9: frame_waiting is 1 while a queue word is offered or a held word is pending, and 0 otherwise.
- R10: While any bit of the 2-bit flush_req is set: src_ready is 1 so offered words are dropped, frame_waiting is 0, reads return 0x80000007, and any held word is discarded. The framer returns to the start of a frame, so the next frame's header is returned raw.
- R11: The read word holds its value in every cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_valid | input | 1 | Queue offers a word |
| src_ready | output | 1 | Word taken (or dropped during flush) at this edge |
| src_word | input | 32 | Offered queue word |
| src_last | input | 1 | Offered word is the last of its frame |
| src_nbytes | input | 2 | Valid bytes of the last word, 0 means 4 |
| src_abort | input | 1 | Frame is aborted (sampled with the last word) |
| src_prune | input | 1 | Frame is truncated (sampled with the last word) |
| flush_req | input | 2 | Any set bit drains the queue and resets framing |
| cpu_rd | input | 1 | Read strobe, one word per cycle it is high |
| cpu_word | output | 32 | Word returned by the latest read |
| frame_waiting | output | 1 | A frame word is available to read |

## Verification
The assertions assume a few things about the queue side. A frame has at least HDR_WORDS+1 words. The abort and prune flags and the byte count are meaningful only on the last word. An offered word stays on the port until it is taken. The stimulus builds every frame with at least one payload word beyond the header, sets flags only on the last word, and changes the offered word only after the handshake has moved the queue on. Reads are issued in bursts sized from the expected word count. A not-ready read happens only when the queue is known to be empty.

// File: rtl/xfr_pkg.sv
package xfr_pkg;

    localparam int WORD_W = 32;

    localparam logic [WORD_W-1:0] MK_END4  = 32'h8000_0000;
    localparam logic [WORD_W-1:0] MK_PRUNE = 32'h8000_0004;
    localparam logic [WORD_W-1:0] MK_ABORT = 32'h8000_0005;
    localparam logic [WORD_W-1:0] MK_ESC   = 32'h8000_0006;
    localparam logic [WORD_W-1:0] MK_NRDY  = 32'h8000_0007;

    // word parked between a marker and the raw word that follows it
    typedef struct packed {
        logic              vld;
        logic              last;
        logic [WORD_W-1:0] word;
    } hold_t;

    typedef enum logic [1:0] {
        CLS_RAW,
        CLS_ESC,
        CLS_TAIL
    } cls_e;

    function automatic logic in_marker_band(input logic [WORD_W-1:0] w);
        return w[WORD_W-1:3] == 29'h1000_0000;
    endfunction

    // end marker: low bits hold (4 - bytes) mod 4, code 0 means 4 bytes
    function automatic logic [WORD_W-1:0] end_marker(input logic [1:0] nb);
        logic [2:0] gap;
        gap = 3'd4 - {1'b0, nb};
        return MK_END4 | {30'd0, gap[1:0]};
    endfunction

endpackage

// File: rtl/xfr_classify.sv
module xfr_classify
    import xfr_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic              last,
    input  logic [1:0]        nbytes,
    input  logic              abort,
    input  logic              prune,
    input  logic              in_hdr,
    output logic [WORD_W-1:0] emit_word,
    output logic              park,
    output cls_e              cls
);
    always_comb begin
        emit_word = word;
        park      = 1'b0;
        cls       = CLS_RAW;
        if (last) begin
            park = 1'b1;
            cls  = CLS_TAIL;
            if (abort)      emit_word = MK_ABORT;
            else if (prune) emit_word = MK_PRUNE;
            else            emit_word = end_marker(nbytes);
        end else if (!in_hdr && in_marker_band(word)) begin
            park      = 1'b1;
            cls       = CLS_ESC;
            emit_word = MK_ESC;
        end
    end
endmodule

// File: rtl/xfr_hdr_cnt.sv
module xfr_hdr_cnt #(
    parameter int HDR_WORDS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic step,
    output logic in_hdr
);
    localparam int CNT_W = $clog2(HDR_WORDS + 1);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(HDR_WORDS);

    logic [CNT_W-1:0] cnt_q;

    assign in_hdr = cnt_q < CNT_TOP;

    always_ff @(posedge clk) begin
        if (rst || clr)          cnt_q <= '0;
        else if (step && in_hdr) cnt_q <= cnt_q + 1'b1;
    end

    // R2
    hdr_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_TOP);

    // R2
    hdr_restart_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> in_hdr);
endmodule

// File: rtl/xfr_hold.sv
module xfr_hold
    import xfr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              drop,
    input  logic              load,
    input  logic              last,
    input  logic [WORD_W-1:0] word,
    output hold_t             hold
);
    always_ff @(posedge clk) begin
        if (rst || drop) begin
            hold <= '0;
        end else if (load) begin
            hold.vld  <= 1'b1;
            hold.last <= last;
            hold.word <= word;
        end
    end
endmodule

// File: rtl/xfr_framer.sv
module xfr_framer
    import xfr_pkg::*;
#(
    parameter int HDR_WORDS = 4,
    parameter int FLUSH_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              src_valid,
    output logic              src_ready,
    input  logic [WORD_W-1:0] src_word,
    input  logic              src_last,
    input  logic [1:0]        src_nbytes,
    input  logic              src_abort,
    input  logic              src_prune,
    input  logic [FLUSH_W-1:0] flush_req,
    input  logic              cpu_rd,
    output logic [WORD_W-1:0] cpu_word,
    output logic              frame_waiting
);
    logic              flushing;
    logic              take;
    logic              in_hdr;
    logic              park;
    logic [WORD_W-1:0] emit_word;
    cls_e              cls;
    hold_t             hold_q;
    logic              give_hold;
    logic              frame_done;

    assign flushing      = |flush_req;
    assign give_hold     = cpu_rd && !flushing && hold_q.vld;
    assign take          = cpu_rd && !flushing && !hold_q.vld && src_valid;
    assign src_ready     = flushing || take;
    assign frame_done    = give_hold && hold_q.last;
    assign frame_waiting = !flushing && (src_valid || hold_q.vld);

    xfr_classify u_cls (
        .word      (src_word),
        .last      (src_last),
        .nbytes    (src_nbytes),
        .abort     (src_abort),
        .prune     (src_prune),
        .in_hdr    (in_hdr),
        .emit_word (emit_word),
        .park      (park),
        .cls       (cls)
    );

    xfr_hdr_cnt #(.HDR_WORDS(HDR_WORDS)) u_hdr (
        .clk    (clk),
        .rst    (rst),
        .clr    (flushing || frame_done),
        .step   (take),
        .in_hdr (in_hdr)
    );

    xfr_hold u_hold (
        .clk  (clk),
        .rst  (rst),
        .drop (flushing || give_hold),
        .load (take && park),
        .last (src_last),
        .word (src_word),
        .hold (hold_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cpu_word <= MK_NRDY;
        end else if (cpu_rd) begin
            if (flushing)        cpu_word <= MK_NRDY;
            else if (hold_q.vld) cpu_word <= hold_q.word;
            else if (src_valid)  cpu_word <= emit_word;
            else                 cpu_word <= MK_NRDY;
        end
    end

    // R11
    word_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cpu_rd |=> $stable(cpu_word));

    // R8
    nrdy_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_rd && !frame_waiting |=> cpu_word == MK_NRDY);

    // R8
    no_spurious_take_chk: assert property (@(posedge clk) disable iff (rst)
        src_ready && !flushing |-> src_valid && cpu_rd);

    // R4
    held_blocks_take_chk: assert property (@(posedge clk) disable iff (rst)
        hold_q.vld && !flushing |-> !src_ready);

    // R5
    tail_parked_chk: assert property (@(posedge clk) disable iff (rst)
        take && src_last |=> hold_q.vld && hold_q.last);

    // R10
    flush_read_chk: assert property (@(posedge clk) disable iff (rst)
        flushing && cpu_rd |=> cpu_word == MK_NRDY);

    // R10
    flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
        flushing |=> !hold_q.vld);

    // R4
    escape_kind_chk: assert property (@(posedge clk) disable iff (rst)
        take && cls == CLS_ESC |=> cpu_word == MK_ESC);
endmodule

// File: tb/sim_xfr_framer.sv
`timescale 1ns/1ps
module sim_xfr_framer;
    localparam logic [31:0] NRDY = 32'h8000_0007;

    typedef struct packed {
        logic [31:0] w;
        logic        l;
        logic [1:0]  nb;
        logic        ab;
        logic        pr;
    } sw_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        src_valid = 1'b0;
    logic        src_ready;
    logic [31:0] src_word = '0;
    logic        src_last = 1'b0;
    logic [1:0]  src_nbytes = '0;
    logic        src_abort = 1'b0;
    logic        src_prune = 1'b0;
    logic [1:0]  flush_req = '0;
    logic        cpu_rd = 1'b0;
    logic [31:0] cpu_word;
    logic        frame_waiting;

    int          n_vec = 0;
    int          n_bad = 0;
    string       cur_req = "R1";
    sw_t         src_q[$];
    logic [31:0] exp_q[$];
    logic        hs_q = 1'b0;
    logic        rd_seen = 1'b0;
    logic [31:0] last_seen = NRDY;

    always #2.5 clk = ~clk;

    xfr_framer u0 (
        .clk(clk), .rst(rst), .src_valid(src_valid), .src_ready(src_ready),
        .src_word(src_word), .src_last(src_last), .src_nbytes(src_nbytes),
        .src_abort(src_abort), .src_prune(src_prune), .flush_req(flush_req),
        .cpu_rd(cpu_rd), .cpu_word(cpu_word), .frame_waiting(frame_waiting)
    );

    always @(posedge clk) begin
        hs_q    <= src_valid && src_ready;
        rd_seen <= cpu_rd && !rst;
    end

    // queue model: advance after a handshake, then offer the head word
    always @(negedge clk) begin
        if (hs_q && src_q.size() > 0) void'(src_q.pop_front());
        if (src_q.size() > 0) begin
            src_valid  = 1'b1;
            src_word   = src_q[0].w;
            src_last   = src_q[0].l;
            src_nbytes = src_q[0].nb;
            src_abort  = src_q[0].ab;
            src_prune  = src_q[0].pr;
        end else begin
            src_valid = 1'b0;
            src_last  = 1'b0;
            src_abort = 1'b0;
            src_prune = 1'b0;
        end
    end

    // monitor: compare every read result against the scoreboard
    always @(negedge clk) begin
        if (rd_seen) begin
            n_vec++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL %s unexpected read got %h exp none", cur_req, cpu_word);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                if (cpu_word !== e) begin
                    n_bad++;
                    $display("FAIL %s read got %h exp %h", cur_req, cpu_word, e);
                end
                last_seen = e;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h exp %h", req, got, exp);
        end
    endtask

    task automatic src_push(input logic [31:0] w, input logic l, input logic [1:0] nb,
                            input logic ab, input logic pr);
        sw_t s;
        s.w = w; s.l = l; s.nb = nb; s.ab = ab; s.pr = pr;
        @(posedge clk);
        src_q.push_back(s);
    endtask

    function automatic logic in_band(input logic [31:0] w);
        return (w >= 32'h8000_0000) && (w <= 32'h8000_0007);
    endfunction

    function automatic logic [31:0] tail_code(input logic [1:0] nb, input logic ab,
                                              input logic pr);
        if (ab) return 32'h8000_0005;
        if (pr) return 32'h8000_0004;
        case (nb)
            2'd0: return 32'h8000_0000;
            2'd1: return 32'h8000_0003;
            2'd2: return 32'h8000_0002;
            default: return 32'h8000_0001;
        endcase
    endfunction

    // queues one frame and its expected read words; returns the read count
    task automatic frame(input logic [31:0] base, input int npay, input logic [31:0] special,
                         input int spos, input logic [1:0] nb, input logic ab,
                         input logic pr, output int nreads);
        nreads = 0;
        for (int i = 0; i < 4; i++) begin
            logic [31:0] h;
            h = (i == 1) ? 32'h8000_0002 : base + 32'(i);
            src_push(h, 1'b0, 2'd0, 1'b0, 1'b0);
            exp_q.push_back(h);
            nreads++;
        end
        for (int i = 0; i < npay; i++) begin
            logic [31:0] w;
            w = (i == spos) ? special : 32'h1000_0000 + base + 32'(i);
            if (i == npay - 1) begin
                src_push(w, 1'b1, nb, ab, pr);
                exp_q.push_back(tail_code(nb, ab, pr));
                exp_q.push_back(w);
                nreads += 2;
            end else begin
                src_push(w, 1'b0, 2'd0, 1'b0, 1'b0);
                if (in_band(w)) begin
                    exp_q.push_back(32'h8000_0006);
                    nreads++;
                end
                exp_q.push_back(w);
                nreads++;
            end
        end
    endtask

    task automatic reads(input int n);
        @(negedge clk);
        cpu_rd = 1'b1;
        repeat (n) @(negedge clk);
        cpu_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic sample();
        @(negedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (exp_q.size() != 0) begin
            n_vec++;
            n_bad++;
            $display("FAIL %s leftover expected words got %0d exp 0", cur_req, exp_q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog got timeout exp completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int n;
        int m;
        repeat (4) @(posedge clk);
        rst = 1'b0;
        sample();
        // R1 reset state
        chk("R1 word", cpu_word, NRDY);
        chk("R1 waiting", {31'd0, frame_waiting}, 32'd0);
        chk("R1 ready", {31'd0, src_ready}, 32'd0);

        // R8 idle read returns not-ready
        cur_req = "R8";
        exp_q.push_back(NRDY);
        reads(1);

        // R2 R3 R5 plain frame, 4-byte tail
        cur_req = "R2/R3/R5";
        frame(32'h0000_0100, 5, 32'd0, -1, 2'd0, 1'b0, 1'b0, n);
        sample();
        chk("R9 waiting set", {31'd0, frame_waiting}, 32'd1);
        reads(n);
        sample();
        chk("R9 waiting clear", {31'd0, frame_waiting}, 32'd0);
        repeat (3) @(negedge clk);
        chk("R11 word held", cpu_word, last_seen);

        // R4 escape mid-payload, 1-byte tail
        cur_req = "R4/R5";
        frame(32'h0000_0200, 4, 32'h8000_0007, 1, 2'd1, 1'b0, 1'b0, n);
        reads(n);

        // R4 R5 back-to-back frames: 2- and 3-byte tails, header restart
        cur_req = "R4/R5 back-to-back";
        frame(32'h0000_0300, 3, 32'h8000_0000, 0, 2'd2, 1'b0, 1'b0, n);
        frame(32'h0000_0400, 2, 32'd0, -1, 2'd3, 1'b0, 1'b0, m);
        reads(n + m);

        // R6 pruned tail
        cur_req = "R6";
        frame(32'h0000_0500, 3, 32'd0, -1, 2'd2, 1'b0, 1'b1, n);
        reads(n);

        // R7 aborted tail, and abort over prune
        cur_req = "R7";
        frame(32'h0000_0600, 2, 32'd0, -1, 2'd1, 1'b1, 1'b0, n);
        frame(32'h0000_0700, 2, 32'd0, -1, 2'd0, 1'b1, 1'b1, m);
        reads(n + m);

        // R8 not-ready in the middle of a frame, position kept
        cur_req = "R8 mid-frame";
        for (int i = 0; i < 4; i++) begin
            src_push(32'h0000_0800 + 32'(i), 1'b0, 2'd0, 1'b0, 1'b0);
            exp_q.push_back(32'h0000_0800 + 32'(i));
        end
        src_push(32'h2000_0001, 1'b0, 2'd0, 1'b0, 1'b0);
        exp_q.push_back(32'h2000_0001);
        reads(5);
        exp_q.push_back(NRDY);
        reads(1);
        src_push(32'h8000_0005, 1'b0, 2'd0, 1'b0, 1'b0);
        exp_q.push_back(32'h8000_0006);
        exp_q.push_back(32'h8000_0005);
        src_push(32'h2000_0003, 1'b1, 2'd0, 1'b0, 1'b0);
        exp_q.push_back(32'h8000_0000);
        exp_q.push_back(32'h2000_0003);
        reads(4);

        // R10 flush drops queued frame
        cur_req = "R10";
        frame(32'h0000_0900, 2, 32'd0, -1, 2'd0, 1'b0, 1'b0, n);
        exp_q.delete();
        sample();
        flush_req = 2'b01;
        sample();
        chk("R10 ready in flush", {31'd0, src_ready}, 32'd1);
        chk("R10 waiting in flush", {31'd0, frame_waiting}, 32'd0);
        exp_q.push_back(NRDY);
        reads(1);
        repeat (8) @(negedge clk);
        flush_req = 2'b00;
        sample();
        chk("R10 queue drained", {31'd0, frame_waiting}, 32'd0);

        // R10 flush while an escaped word is held, then a fresh frame
        cur_req = "R10 mid-escape";
        for (int i = 0; i < 4; i++) begin
            src_push(32'h0000_0a00 + 32'(i), 1'b0, 2'd0, 1'b0, 1'b0);
            exp_q.push_back(32'h0000_0a00 + 32'(i));
        end
        src_push(32'h8000_0001, 1'b0, 2'd0, 1'b0, 1'b0);
        exp_q.push_back(32'h8000_0006);
        reads(5);
        sample();
        chk("R9 held word waiting", {31'd0, frame_waiting}, 32'd1);
        flush_req = 2'b10;
        sample();
        chk("R10 waiting in flush", {31'd0, frame_waiting}, 32'd0);
        repeat (2) @(negedge clk);
        flush_req = 2'b00;
        sample();
        chk("R10 held word dropped", {31'd0, frame_waiting}, 32'd0);
        cur_req = "R10 restart header";
        frame(32'h0000_0b00, 2, 32'd0, -1, 2'd0, 1'b0, 1'b0, n);
        reads(n);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule